// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps an 8-bit record of the reason for the most recent system reset. Four single-cycle event inputs report a power-on, an external pin reset, a brown-out and a watchdog reset. Each event raises its own sticky flag. The flag stays set until software clears it by writing zero to that bit through a simple write port. The read port always shows the current flags.

Boot firmware reads the word soon after startup to learn why the chip restarted. It then writes zeros to clear it, so that the next reset can be told apart from earlier ones. The flag storage is not wired to the chip's ordinary reset tree, so it keeps its contents through watchdog, brown-out and external resets. A power-on event is the one exception: it clears the other three flags and leaves only its own flag set. The rst_ni input only brings the storage to a defined cold value and does nothing else.

Top module: `rst_cause_reg`

## Requirements
- R1: Read bits 7 to 4 are always zero, whatever was written or signalled.
- R2: Flag positions are bit 3 watchdog, bit 2 brown-out, bit 1 external, bit 0 power-on. An event pulse sets its flag, and the flag is visible on the read port in the cycle after the event.
- R3: Without an event, a power-on event or a write of zero to its bit, every flag keeps its value.
- R4: A write with a zero in bit k (k from 0 to 3) clears flag k in the next cycle. A one in bit k leaves flag k unchanged, so software can never set a flag.
- R5: When a set event and a write of zero to the same bit occur in one cycle, the flag ends up set.
- R6: A power-on event makes the next read value exactly 0x01, whatever the earlier state, any simultaneous events or any simultaneous write.
- R7: The power-on flag (bit 0) is cleared only by a write of zero to bit 0. Watchdog, brown-out and external events leave it unchanged.
- R8: While rst_ni is low, the read value is 0x00.
- R9: After software writes 0x00, a single later watchdog, brown-out or external event leaves exactly that event's bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold initialisation of the flag storage |
| por_evt_i | input | 1 | Power-on event pulse |
| ext_evt_i | input | 1 | External pin reset event pulse |
| bod_evt_i | input | 1 | Brown-out reset event pulse |
| wdt_evt_i | input | 1 | Watchdog reset event pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data; a zero in bit k clears flag k |
| rd_data_o | output | 8 | Current flag word |

## Verification
The hardest case to reach from the ports is a flag word holding an arbitrary mix of stale flags when a new event and a software clear land in the same cycle. Power-on always wipes bits 1 to 3, and there is no way to set a flag directly. The bench therefore builds each of the 16 flag states in a fixed order. It first issues a power-on pulse, then fires the wanted events for bits 1 to 3 together, and finally writes zero to bit 0 if that flag must be low. From each state it applies every combination of event inputs, either with no write or with each of the 16 write patterns, and checks the following read value.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int REG_W   = 8;
  localparam int FLAG_W  = 4;
  // bit positions; firmware decodes these
  localparam int BIT_POR = 0;
  localparam int BIT_EXT = 1;
  localparam int BIT_BOD = 2;
  localparam int BIT_WDT = 3;
endpackage

// File: rtl/rst_flag_cell.sv
module rst_flag_cell #(
  parameter bit WIPE_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wipe_i,
  input  logic clr_i,
  output logic flag_o
);
  logic wipe;
  logic flag_q;

  generate
    if (WIPE_EN) begin : g_wipe
      assign wipe = wipe_i;
    end else begin : g_nowipe
      logic unused_wipe;
      assign unused_wipe = wipe_i;
      assign wipe = 1'b0;
    end
  endgenerate

  // priority: power-on wipe > set event > software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (wipe)    flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wipe) |=> flag_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !wipe && !clr_i) |=> $stable(flag_o));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !wipe) |=> !flag_o);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i && !wipe) |=> flag_o);
endmodule

// File: rtl/rst_cause_rdmux.sv
module rst_cause_rdmux #(
  parameter int REG_W  = 8,
  parameter int FLAG_W = 4
) (
  input  logic [FLAG_W-1:0] flags_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int PAD_W = REG_W - FLAG_W;
  assign rd_data_o = {{PAD_W{1'b0}}, flags_i};
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_evt_i,
  input  logic             ext_evt_i,
  input  logic             bod_evt_i,
  input  logic             wdt_evt_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  localparam logic [REG_W-1:0] POR_WORD = REG_W'(1) << BIT_POR;

  logic [FLAG_W-1:0] evt_vec;
  logic [FLAG_W-1:0] flags;
  logic              unused_wdata;

  assign evt_vec[BIT_POR] = por_evt_i;
  assign evt_vec[BIT_EXT] = ext_evt_i;
  assign evt_vec[BIT_BOD] = bod_evt_i;
  assign evt_vec[BIT_WDT] = wdt_evt_i;
  assign unused_wdata = ^wr_data_i[REG_W-1:FLAG_W];

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    rst_flag_cell #(.WIPE_EN(k != BIT_POR)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_vec[k]),
      .wipe_i (por_evt_i),
      .clr_i  (wr_en_i & ~wr_data_i[k]),
      .flag_o (flags[k])
    );
  end

  rst_cause_rdmux #(.REG_W(REG_W), .FLAG_W(FLAG_W)) u_rdmux (
    .flags_i   (flags),
    .rd_data_o (rd_data_o)
  );

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:FLAG_W] == '0);
  assert_por_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> (rd_data_o == POR_WORD));
  assert_por_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_evt_i && !(wr_en_i && !wr_data_i[BIT_POR]))
      |=> $stable(rd_data_o[BIT_POR]));
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 0, ext = 0, bod = 0, wdt = 0, wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  rst_cause_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_evt_i(por), .ext_evt_i(ext),
    .bod_evt_i(bod), .wdt_evt_i(wdt), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // evt bits: [0]=por [1]=ext [2]=bod [3]=wdt
  task automatic step(input logic [3:0] e, input logic w, input logic [7:0] d);
    por = e[0]; ext = e[1]; bod = e[2]; wdt = e[3];
    wr_en = w; wr_data = d;
    @(posedge clk); #1;
    por = 0; ext = 0; bod = 0; wdt = 0; wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic build(input logic [3:0] s);
    step(4'b0001, 1'b0, 8'h00);
    if (s[3:1] != 3'b000) step({s[3:1], 1'b0}, 1'b0, 8'h00);
    if (!s[0]) step(4'b0000, 1'b1, 8'hFE);
  endtask

  initial begin
    while (cyc < WDOG_CYC && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WDOG_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R8 during reset", rd, 8'h00);
    repeat (2) @(posedge clk);
    #1;
    chk("R8 held reset", rd, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 after release", rd, 8'h00);

    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int wi = 0; wi < 17; wi++) begin
          logic       w;
          logic [7:0] d;
          logic [3:0] nxt;
          string      tag;
          w = (wi != 16);
          d = {4'(wi * 7 + s), 4'(wi)};
          build(4'(s));
          chk("R3 setup state", rd, {4'h0, 4'(s)});
          if (e[0]) nxt = 4'b0001;
          else
            for (int k = 0; k < 4; k++)
              nxt[k] = e[k] ? 1'b1 : ((w && !d[k]) ? 1'b0 : s[k]);
          if (e[0])           tag = "R6 power-on";
          else if (e != 0 && w) tag = "R5 set vs clear";
          else if (e != 0)    tag = "R2 event set";
          else if (w)         tag = "R4 write";
          else                tag = "R3 hold";
          step(4'(e), w, d);
          chk(tag, {4'h0, rd[3:0]}, {4'h0, nxt});
          chk("R1 reserved", {rd[7:4], 4'h0}, 8'h00);
          if (!e[0] && !(w && !d[0]))
            chk("R7 por flag kept", {7'h0, rd[0]}, {7'h0, s[0]});
        end
      end
    end

    for (int k = 1; k < 4; k++) begin
      step(4'b1111, 1'b0, 8'h00);
      step(4'b0000, 1'b1, 8'h00);
      chk("R9 cleared", rd, 8'h00);
      step(4'(1 << k), 1'b0, 8'h00);
      chk("R9 single cause", rd, 8'(1 << k));
    end

    step(4'b1110, 1'b0, 8'h00);
    rst_n = 1'b0;
    #2;
    chk("R8 async reset", rd, 8'h00);
    rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule